// File: doc/BRIEF.md
# Content-Addressable Word Store with Miss Flag

This block is a small register-based store whose words can be written and read by address, like an ordinary RAM, and can also be searched. A search presents a key on the same bus that carries write data. Every stored word is compared with that key in the same cycle. The result is a per-word hit vector plus an aggregate miss flag that is the NOR of all hit lines. No word is addressed during a search. Several words may hit at once, and the whole vector is reported without any priority encoding.

Each cycle carries one operation. When several strobes are high together, a write wins over a search, and a search wins over a read.

A small control state machine records the operation carried out at the last clock edge. It has four states:

- `ST_IDLE`: no strobe was taken.
- `ST_WRITE`: a write was taken.
- `ST_SEARCH`: a search was taken.
- `ST_READ`: a read was taken.

Transitions happen from every state on every edge, and the next state is chosen by the prioritised strobes:

- `wr_en` leads to `ST_WRITE`.
- Otherwise `srch_en` leads to `ST_SEARCH`.
- Otherwise `rd_en` leads to `ST_READ`.
- Otherwise the machine goes to `ST_IDLE`.

`hit_valid` is high exactly while the machine is in `ST_SEARCH`.

Each word has a valid bit. Reset clears every word and every valid bit, and a word that has never been written never hits.

Top module: `cam_array`

## Requirements
- R1: After reset, `rd_data` is zero, `hit_vec` is all zero, `miss` is 0 and `hit_valid` is 0.
- R2: A read strobe with address A loads the word stored at A into `rd_data` at that clock edge. The value is visible in the following cycle and held until the next read that is carried out.
- R3: A search strobe with key K sets bit i of `hit_vec` exactly when word i is valid and equals K. The result is registered at that edge, and `hit_valid` is 1 for the one following cycle only.
- R4: When several words equal the key, every one of their bits in `hit_vec` is set.
- R5: With each search result, `miss` is 1 exactly when no bit of `hit_vec` is set.
- R6: A word that has not been written since reset never sets its `hit_vec` bit, even if the key equals its cleared contents (zero).
- R7: A word written at one edge is seen by a search taken at the very next edge.
- R8: When `wr_en` is high, only the write is carried out, whatever the other strobes are. In the next cycle `hit_valid` is 0, and `rd_data`, `hit_vec` and `miss` are unchanged.
- R9: When `srch_en` and `rd_en` are high without `wr_en`, only the search is carried out, and `rd_data` keeps its value.
- R10: `hit_vec` and `miss` keep their last search result through every cycle in which no search is carried out, including writes that change matching words.
- R11: An address at or above WORDS selects no word. A write to it stores nothing, and a read from it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | AW | Word address for read and write |
| bus_in | input | WIDTH | Write data, or the search key |
| wr_en | input | 1 | Write strobe (highest priority) |
| srch_en | input | 1 | Search strobe |
| rd_en | input | 1 | Read strobe (lowest priority) |
| rd_data | output | WIDTH | Registered read data |
| hit_vec | output | WORDS | Registered per-word hit lines |
| miss | output | 1 | Registered NOR of the hit lines |
| hit_valid | output | 1 | One-cycle pulse marking a fresh search result |

## Verification
The bench builds the block with WORDS = 6 and WIDTH = 8. With these values the address is three bits wide, so addresses 6 and 7 exist on the port but select no word. This makes the out-of-range write and read of R11 reachable. Six words are enough to place three equal values and show a multi-hit vector. The still-zero contents after reset let a search for zero prove that invalid words stay silent.

// File: rtl/cam_pkg.sv
package cam_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_SEARCH = 2'd2,
        ST_READ   = 2'd3
    } cam_state_t;
endpackage

// File: rtl/cam_ctrl.sv
module cam_ctrl
    import cam_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       srch_en,
    input  logic       rd_en,
    output logic       wr_go,
    output logic       srch_go,
    output logic       rd_go,
    output logic       hit_valid
);
    cam_state_t state_q;
    cam_state_t state_d;

    // next state: write over search over read
    always_comb begin
        if (wr_en)        state_d = ST_WRITE;
        else if (srch_en) state_d = ST_SEARCH;
        else if (rd_en)   state_d = ST_READ;
        else              state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_go   = 1'b0;
        srch_go = 1'b0;
        rd_go   = 1'b0;
        unique case (state_d)
            ST_IDLE:   ;
            ST_WRITE:  wr_go   = 1'b1;
            ST_SEARCH: srch_go = 1'b1;
            ST_READ:   rd_go   = 1'b1;
            default:   ;
        endcase
        hit_valid = (state_q == ST_SEARCH);
    end

    // R3
    search_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_en && !wr_en) |=> hit_valid);

    // R8
    write_blocks_search_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hit_valid);

    // R3
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_go, srch_go, rd_go}));
endmodule

// File: rtl/cam_row.sv
module cam_row #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] key,
    output logic [WIDTH-1:0] word,
    output logic             hit
);
    logic             valid_q;
    logic [WIDTH-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            data_q  <= '0;
        end else if (we) begin
            valid_q <= 1'b1;
            data_q  <= wdata;
        end
    end

    always_comb begin
        word = data_q;
        hit  = valid_q && (data_q == key);
    end

    // R6
    invalid_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_q |-> !hit);
endmodule

// File: rtl/cam_array.sv
module cam_array
    import cam_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 8,
    localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] bus_in,
    input  logic             wr_en,
    input  logic             srch_en,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [WORDS-1:0] hit_vec,
    output logic             miss,
    output logic             hit_valid
);
    localparam logic [AW:0] WORDS_W = (AW+1)'(WORDS);

    logic             wr_go;
    logic             srch_go;
    logic             rd_go;
    logic             in_range;
    logic [WORDS-1:0] cmp;
    logic [WIDTH-1:0] row_word [WORDS];
    logic [WIDTH-1:0] rd_word;
    logic [WIDTH-1:0] rd_q;
    logic [WORDS-1:0] hit_q;
    logic             miss_q;

    cam_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .srch_en   (srch_en),
        .rd_en     (rd_en),
        .wr_go     (wr_go),
        .srch_go   (srch_go),
        .rd_go     (rd_go),
        .hit_valid (hit_valid)
    );

    assign in_range = ({1'b0, addr} < WORDS_W);

    for (genvar g = 0; g < WORDS; g++) begin : g_row
        cam_row #(.WIDTH(WIDTH)) u_row (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_go && in_range && (addr == AW'(g))),
            .wdata (bus_in),
            .key   (bus_in),
            .word  (row_word[g]),
            .hit   (cmp[g])
        );
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (in_range && addr == AW'(i)) rd_word = row_word[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q   <= '0;
            hit_q  <= '0;
            miss_q <= 1'b0;
        end else begin
            if (rd_go) rd_q <= rd_word;
            if (srch_go) begin
                hit_q  <= cmp;
                miss_q <= ~|cmp;
            end
        end
    end

    assign rd_data = rd_q;
    assign hit_vec = hit_q;
    assign miss    = miss_q;

    // R5
    miss_is_nor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> (miss == (hit_vec == '0)));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(srch_en && !wr_en) |=> ($stable(hit_vec) && $stable(miss)));

    // R8
    write_keeps_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> $stable(rd_data));

    // R9
    search_keeps_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |=> $stable(rd_data));
endmodule

// File: tb/sim_cam_array.sv
`timescale 1ns/1ps
module sim_cam_array;
    localparam int WORDS = 6;
    localparam int WIDTH = 8;
    localparam int AW    = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [AW-1:0]    addr;
    logic [WIDTH-1:0] bus_in;
    logic             wr_en, srch_en, rd_en;
    logic [WIDTH-1:0] rd_data;
    logic [WORDS-1:0] hit_vec;
    logic             miss, hit_valid;

    int tests = 0;
    int fails = 0;
    logic [WIDTH-1:0] last_rd = '0;

    always #10 clk = ~clk;

    cam_array #(.WORDS(WORDS), .WIDTH(WIDTH)) u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .bus_in(bus_in),
        .wr_en(wr_en), .srch_en(srch_en), .rd_en(rd_en),
        .rd_data(rd_data), .hit_vec(hit_vec), .miss(miss), .hit_valid(hit_valid)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; bus_in = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [WIDTH-1:0] exp,
                           input string req);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        chk(rd_data == exp, req, "rd_data", 32'(rd_data), 32'(exp));
        last_rd = exp;
    endtask

    task automatic do_search(input logic [WIDTH-1:0] key, input logic [WORDS-1:0] exp,
                             input string req);
        @(negedge clk);
        srch_en = 1'b1; bus_in = key;
        @(negedge clk);
        srch_en = 1'b0;
        chk(hit_valid == 1'b1, req, "hit_valid", 32'(hit_valid), 32'd1);
        chk(hit_vec == exp, req, "hit_vec", 32'(hit_vec), 32'(exp));
        chk(miss == (exp == '0), req, "miss", 32'(miss), 32'(exp == '0));
    endtask

    task automatic t_reset();
        chk(rd_data == '0, "R1", "rd_data", 32'(rd_data), 0);
        chk(hit_vec == '0, "R1", "hit_vec", 32'(hit_vec), 0);
        chk(miss == 1'b0, "R1", "miss", 32'(miss), 0);
        chk(hit_valid == 1'b0, "R1", "hit_valid", 32'(hit_valid), 0);
        do_search(8'h00, 6'b000000, "R6");
    endtask

    task automatic t_basic();
        logic [WIDTH-1:0] vals [WORDS] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
        for (int i = 0; i < WORDS; i++) do_write(AW'(i), vals[i]);
        for (int i = 0; i < WORDS; i++) do_read(AW'(i), vals[i], "R2");
        do_search(8'h33, 6'b000100, "R3");
    endtask

    task automatic t_multi();
        do_write(3'd1, 8'h33);
        do_write(3'd4, 8'h33);
        do_search(8'h33, 6'b010110, "R4");
    endtask

    task automatic t_miss();
        do_search(8'h99, 6'b000000, "R5");
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd0; bus_in = 8'hA5;
        @(negedge clk);
        wr_en = 1'b0; srch_en = 1'b1; bus_in = 8'hA5;
        @(negedge clk);
        srch_en = 1'b0;
        chk(hit_valid == 1'b1, "R7", "hit_valid", 32'(hit_valid), 1);
        chk(hit_vec == 6'b000001, "R7", "hit_vec", 32'(hit_vec), 32'h1);
    endtask

    task automatic t_write_priority();
        @(negedge clk);
        wr_en = 1'b1; srch_en = 1'b1; rd_en = 1'b1; addr = 3'd5; bus_in = 8'h77;
        @(negedge clk);
        wr_en = 1'b0; srch_en = 1'b0; rd_en = 1'b0;
        chk(hit_valid == 1'b0, "R8", "hit_valid", 32'(hit_valid), 0);
        chk(rd_data == last_rd, "R8", "rd_data", 32'(rd_data), 32'(last_rd));
        chk(hit_vec == 6'b000001, "R8", "hit_vec", 32'(hit_vec), 32'h1);
        do_read(3'd5, 8'h77, "R8");
        do_search(8'h66, 6'b000000, "R8");
    endtask

    task automatic t_search_priority();
        @(negedge clk);
        srch_en = 1'b1; rd_en = 1'b1; addr = 3'd0; bus_in = 8'h44;
        @(negedge clk);
        srch_en = 1'b0; rd_en = 1'b0;
        chk(rd_data == last_rd, "R9", "rd_data", 32'(rd_data), 32'(last_rd));
        chk(hit_valid == 1'b1, "R9", "hit_valid", 32'(hit_valid), 1);
        chk(hit_vec == 6'b001000, "R9", "hit_vec", 32'(hit_vec), 32'h8);
    endtask

    task automatic t_hold();
        do_write(3'd2, 8'h44);
        @(negedge clk);
        chk(hit_valid == 1'b0, "R10", "hit_valid", 32'(hit_valid), 0);
        chk(hit_vec == 6'b001000, "R10", "hit_vec", 32'(hit_vec), 32'h8);
        chk(miss == 1'b0, "R10", "miss", 32'(miss), 0);
        do_search(8'h44, 6'b001100, "R10");
    endtask

    task automatic t_out_of_range();
        do_write(3'd6, 8'h5A);
        do_search(8'h5A, 6'b000000, "R11");
        do_read(3'd7, 8'h00, "R11");
        do_read(3'd6, 8'h00, "R11");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; addr = '0; bus_in = '0;
        wr_en = 1'b0; srch_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_multi();
        t_miss();
        t_back_to_back();
        t_write_priority();
        t_search_priority();
        t_hold();
        t_out_of_range();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule